// File: doc/BRIEF.md
# Reassembly Buffer Slip Guard

This block sits in front of a circular reassembly buffer. A cell writer deposits payload into the buffer in blocks of 47 bytes, and a TDM reader drains it on a clock of its own. When a cell arrives, the guard measures how far the stored write pointer runs ahead of the reader's current position. It then decides whether the cell can go where the writer expects, or whether the two pointers have drifted too far apart.

The lead is the write pointer minus the read pointer, taken modulo the configured buffer size. A lead shorter than one cell means the reader would catch up within the cell and replay stale bytes. That case is an underrun. A lead beyond the configured maximum is an overflow. In both slip cases the guard re-centres the writer to the read pointer plus half the maximum lead. It writes the cell there and bumps the statistic that matches the slip. Set the maximum lead to at least 94 (two cells), so that one late cell is not taken for a gross slip. A usual sizing is twice the line's frame byte rate times the expected cell delay variation, plus 94. The first cell after reset always re-centres, which seeds the write pointer.

Top module: `slip_guard`

## Requirements
- R1: While reset is asserted and on the first cycle after it, wr_en, underrun and overflow are 0, and both counters read 0.
- R2: wr_en pulses high for exactly one cycle, in the cycle after each cycle with cell_valid high, and is low otherwise.
- R3: Lead = (write pointer − rd_ptr) mod buf_size. When the lead is in [47, max_lead], the cell is placed at the stored write pointer (wr_addr), and the stored pointer then advances by 47 modulo buf_size.
- R4: When the lead is below 47 (including 0), underrun pulses with wr_en. wr_addr = (rd_ptr + floor(max_lead/2)) mod buf_size. under_cnt increments, the next pointer is wr_addr+47 mod buf_size, and overflow stays low.
- R5: When the lead exceeds max_lead, overflow pulses with wr_en, wr_addr is re-centred as in R4, and over_cnt increments. underrun stays low.
- R6: The first cell after reset is placed at (rd_ptr + floor(max_lead/2)) mod buf_size. It raises neither slip flag and changes neither counter.
- R7: under_cnt and over_cnt stop at their all-ones value instead of wrapping.
- R8: Lead, re-centred address and advanced pointer all wrap at buf_size, which may be any value up to 2^AW. max_lead must be below buf_size.
- R9: When max_lead is below 47 and the lead is below 47, the cell is classed as an underrun, not an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | One cycle per arriving cell |
| rd_ptr | input | AW | Reader's current buffer position |
| max_lead | input | AW | Largest permitted lead, in bytes |
| buf_size | input | AW+1 | Buffer length in bytes |
| wr_en | output | 1 | Cell placement strobe |
| wr_addr | output | AW | Start address for the cell's 47 bytes |
| underrun | output | 1 | Cell was re-centred after an underrun |
| overflow | output | 1 | Cell was re-centred after an overflow |
| under_cnt | output | CNT_W | Saturating underrun statistic |
| over_cnt | output | CNT_W | Saturating overflow statistic |

## Verification
A corrupted stored write pointer has no output of its own. It shows up at the next arriving cell: wr_addr departs from the previous address plus 47, or a slip flag fires where the lead from the bench's model predicts none. A wrong slip class shows at once in the flag and the counter. A wrong re-centring value shows on the same wr_addr strobe and then on every later address in the run. The bench therefore compares every output on every cycle after a cell, so a divergence is seen within one cell of its cause.

// File: rtl/slip_guard.sv
module slip_guard #(
  parameter int AW    = 12,
  parameter int CNT_W = 16,
  parameter int CELL  = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_valid,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [AW-1:0]    max_lead,
  input  logic [AW:0]      buf_size,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             underrun,
  output logic             overflow,
  output logic [CNT_W-1:0] under_cnt,
  output logic [CNT_W-1:0] over_cnt
);
  localparam logic [AW:0]      CELL_B = CELL[AW:0];
  localparam logic [CNT_W-1:0] CMAX   = '1;

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a, input logic [AW:0] b,
                                             input logic [AW:0] size);
    logic [AW+1:0] s;
    s = {2'b0, a} + {1'b0, b};
    if (s >= {1'b0, size}) s = s - {1'b0, size};
    return s[AW-1:0];
  endfunction

  logic [AW-1:0] wp;
  logic          primed;
  logic [AW:0]   lead;
  logic          is_under, is_over;
  logic [AW-1:0] centre, place;

  assign lead     = (wp >= rd_ptr) ? {1'b0, wp} - {1'b0, rd_ptr}
                                   : {1'b0, wp} + buf_size - {1'b0, rd_ptr};
  assign is_under = lead < CELL_B;
  assign is_over  = !is_under && (lead > {1'b0, max_lead});
  assign centre   = wrap_add(rd_ptr, {2'b0, max_lead[AW-1:1]}, buf_size);
  assign place    = (!primed || is_under || is_over) ? centre : wp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      primed    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      underrun  <= 1'b0;
      overflow  <= 1'b0;
      under_cnt <= '0;
      over_cnt  <= '0;
    end else begin
      wr_en    <= cell_valid;
      underrun <= cell_valid && primed && is_under;
      overflow <= cell_valid && primed && is_over;
      if (cell_valid) begin
        wr_addr <= place;
        wp      <= wrap_add(place, CELL_B, buf_size);
        primed  <= 1'b1;
        if (primed && is_under && under_cnt != CMAX) under_cnt <= under_cnt + 1'b1;
        if (primed && is_over  && over_cnt  != CMAX) over_cnt  <= over_cnt + 1'b1;
      end
    end
  end
endmodule

module slip_guard_chk #(
  parameter int AW    = 12,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cell_valid,
  input logic [AW:0]      buf_size,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic             underrun,
  input logic             overflow,
  input logic [CNT_W-1:0] under_cnt,
  input logic [CNT_W-1:0] over_cnt
);
  AST_STROBE_FOLLOWS_CELL: assert property (@(posedge clk) disable iff (!rst_n) cell_valid |=> wr_en); // R2
  AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !cell_valid |=> !wr_en); // R2
  AST_ONE_SLIP_KIND: assert property (@(posedge clk) disable iff (!rst_n) !(underrun && overflow)); // R9
  AST_SLIP_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (underrun || overflow) |-> wr_en); // R4
  AST_UNDER_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !underrun |-> $stable(under_cnt)); // R4
  AST_OVER_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !overflow |-> $stable(over_cnt)); // R5
  AST_UNDER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) under_cnt >= $past(under_cnt)); // R7
  AST_OVER_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) over_cnt >= $past(over_cnt)); // R7
  AST_ADDR_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> ({1'b0, wr_addr} < buf_size)); // R8
endmodule

bind slip_guard slip_guard_chk #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .buf_size(buf_size),
  .wr_en(wr_en), .wr_addr(wr_addr), .underrun(underrun), .overflow(overflow),
  .under_cnt(under_cnt), .over_cnt(over_cnt)
);

// File: tb/sim_slip_guard.sv
`timescale 1ns/1ps
module sim_slip_guard;
  localparam int AW = 12, CW = 3, CMAX = 7;
  logic clk = 0, rst_n = 0, cell_valid = 0;
  logic [AW-1:0] rd_ptr = '0, max_lead = '0;
  logic [AW:0] buf_size = 13'd1000;
  logic wr_en, underrun, overflow;
  logic [AW-1:0] wr_addr;
  logic [CW-1:0] under_cnt, over_cnt;
  int compared = 0, mismatched = 0;
  int mwp, mu, mo;
  bit mprimed;

  always #10 clk = ~clk;

  slip_guard #(.AW(AW), .CNT_W(CW)) u0 (.*);

  function automatic int mmod(int x, int s);
    return ((x % s) + s) % s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(int size, int ml);
    @(negedge clk);
    rst_n = 0; cell_valid = 0; buf_size = size[AW:0]; max_lead = ml[AW-1:0]; rd_ptr = '0;
    repeat (3) @(negedge clk);
    check(!wr_en && !underrun && !overflow && under_cnt == 0 && over_cnt == 0, "R1 in reset",
          {wr_en, underrun, overflow, under_cnt, over_cnt}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!wr_en && !underrun && !overflow && under_cnt == 0 && over_cnt == 0, "R1 after reset",
          {wr_en, underrun, overflow, under_cnt, over_cnt}, 0);
    mwp = 0; mprimed = 0; mu = 0; mo = 0;
  endtask

  task automatic step(bit v, int rd);
    int size, ml, lead, addr, kind;
    string req;
    size = int'(buf_size); ml = int'(max_lead);
    cell_valid = v; rd_ptr = rd[AW-1:0];
    kind = 0; addr = 0;
    if (v) begin
      lead = mmod(mwp - rd, size);
      if (!mprimed) kind = 3;
      else if (lead < 47) kind = 1;
      else if (lead > ml) kind = 2;
      addr = (kind == 0) ? mwp : mmod(rd + ml / 2, size);
      mwp = mmod(addr + 47, size);
      mprimed = 1;
      if (kind == 1 && mu < CMAX) mu++;
      if (kind == 2 && mo < CMAX) mo++;
    end
    @(posedge clk);
    @(negedge clk);
    cell_valid = 0;
    case (kind)
      1: req = (ml < 47) ? "R9 underrun priority" : "R4 underrun";
      2: req = "R5 overflow";
      3: req = "R6 first cell";
      default: req = v ? "R3 okay" : "R2 idle";
    endcase
    check(wr_en == v, {req, " R2 strobe"}, wr_en, v);
    if (v) check(int'(wr_addr) == addr, {req, " R8 address"}, wr_addr, addr);
    check(underrun == (kind == 1) && overflow == (kind == 2), {req, " flags"},
          {underrun, overflow}, {kind == 1, kind == 2});
    check(int'(under_cnt) == mu && int'(over_cnt) == mo, {req, " R7 counters"},
          {under_cnt, over_cnt}, {mu[CW-1:0], mo[CW-1:0]});
  endtask

  initial begin
    #3000000;
    mismatched++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int rd;
    void'($urandom(32'd1234));
    // directed: first cell, okay, underrun, overflow, wrap
    do_reset(200, 100);
    step(1, 180);          // R6: placed at (180+50)%200 = 30
    step(0, 180);
    step(1, 20);           // lead 77-20=57 -> R3 okay at 77
    step(1, 110);          // wp 124, lead 14 -> R4 underrun, addr 160
    step(1, 0);            // wp 7, lead 7 -> R4
    step(1, 60);           // wp 97, lead 37 -> R4
    step(1, 190);          // wp 157, lead 167 -> R5 overflow, wrap addr 40
    step(1, 10);           // wp 87, lead 77 -> okay
    // R9: max_lead below one cell
    do_reset(1000, 30);
    step(1, 0);            // addr 15
    step(1, 20);           // wp 62, lead 42 -> underrun despite > 30
    step(1, 0);            // wp 82, lead 82 > 30 -> overflow
    // saturation: repeated underruns
    do_reset(500, 94);
    step(1, 0);
    for (int i = 0; i < 12; i++) step(1, mmod(mwp - 10, 500));
    for (int i = 0; i < 12; i++) step(1, mmod(mwp - 300, 500));
    // random phases
    for (int ph = 0; ph < 6; ph++) begin
      int sizes[3] = '{200, 1000, 4096};
      int leads[4] = '{30, 94, 150, 180};
      do_reset(sizes[ph % 3], leads[ph % 4]);
      rd = 0;
      for (int c = 0; c < 2000; c++) begin
        rd = mmod(rd + int'($urandom_range(0, 47)), int'(buf_size));
        step($urandom_range(0, 1) == 1, rd);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule